// File: doc/BRIEF.md
# Byte-Serial 16-bit Move Instruction Decoder

This block takes a stream of 16-bit machine-code bytes, one byte per valid/ready transfer, and splits each instruction of a small data-movement subset into one decoded record. The subset covers the register-immediate short forms, the immediate-to-memory form, the accumulator load from an absolute address, the word load/store and segment-store forms that use a mode/reg/r/m byte, and two add forms: a register add into the r/m operand and an ALU operation with a sign-extended 8-bit immediate.

The parse runs one byte at a time. The first byte selects the format. An optional mode/reg/r/m byte chooses the addressing. After it come any displacement bytes and then any immediate bytes, with multi-byte values arriving low byte first. The finished record carries the instruction class, the kind and number of the destination and source operands, a direct-address flag, the displacement, the immediate, the length in bytes and an illegal flag. While a record waits on its own valid/ready handshake, input bytes are held off. Once the record is taken, the decoder goes back to fetching an opcode.

Top module: `insn_dec16`

## Requirements
- R1: After reset, in_ready_o is 1 and rec_valid_o is 0.
- R2: Bytes B8..BF give class 0. The destination is kind REG with its number taken from opcode bits 2:0, and the source is kind IMM. The next two bytes form the immediate, low byte first, so the length is 3. Operand kind codes: 0 none, 1 REG, 2 MEM, 3 IMM, 4 SEG.
- R3: C7 followed by a mode/reg/r/m byte whose reg field (bits 5:3) is 0 gives class 1. The destination is the r/m operand and the source is a 16-bit IMM that comes after any displacement. For example, C7 04 00 00 decodes as MEM r/m 4, immediate 0000, length 4. If the reg field is not 0, the record is flagged illegal with length 2.
- R4: In the mode/reg/r/m byte, mode is bits 7:6, reg is bits 5:3 and r/m is bits 2:0. Mode 3 gives a REG operand numbered by r/m. Modes 0..2 give a MEM operand whose number field is the r/m code. Mode 0 has no displacement, except r/m 6, which reads a 16-bit direct address and sets rec_direct_o. Mode 1 reads one displacement byte and sign-extends it. Mode 2 reads a 16-bit displacement.
- R5: A1 gives class 2. The destination is REG 0 and the source is MEM with number 6 and rec_direct_o set. The next two bytes are the address, low byte first, and the length is 3.
- R6: For 8B (class 3), the destination is REG numbered by the reg field and the source is the r/m operand. For 89 (class 4) and 01 (class 7), the destination is the r/m operand and the source is REG numbered by the reg field. For example, 01 44 10 decodes as MEM r/m 4, displacement 0010, REG 0, length 3.
- R7: 8C gives class 5. The destination is the r/m operand and the source is kind SEG numbered by the reg field.
- R8: 83 gives class 6. rec_alu_op_o equals the reg field, the destination is the r/m operand, and the source is IMM. The one immediate byte is sign-extended to 16 bits. For example, 83 C1 FF decodes as REG 1, immediate FFFF, length 3.
- R9: Any other opcode byte yields an illegal record of length 1, and the byte after it is parsed as a new opcode. Every illegal record shows class 0, alu op 0, both operand kinds 0 with numbers 0, direct 0, displacement 0 and immediate 0.
- R10: While rec_valid_o is 1 and rec_ready_i is 0, the record stays stable and in_ready_o is 0. In the cycle after a record is accepted, rec_valid_o is 0 and in_ready_o is 1.
- R11: rec_valid_o rises in the cycle right after the last byte of an instruction is accepted, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Input code byte |
| in_ready_o | output | 1 | Decoder accepts a byte |
| rec_valid_o | output | 1 | Decoded record valid |
| rec_ready_i | input | 1 | Record consumer ready |
| rec_illegal_o | output | 1 | Unknown opcode or bad extension field |
| rec_cls_o | output | 3 | Instruction class code |
| rec_alu_op_o | output | 3 | ALU operation from the reg field (class 6) |
| rec_dst_kind_o | output | 3 | Destination operand kind |
| rec_dst_num_o | output | 3 | Destination register, segment or r/m code |
| rec_src_kind_o | output | 3 | Source operand kind |
| rec_src_num_o | output | 3 | Source register, segment or r/m code |
| rec_direct_o | output | 1 | Memory operand is a direct 16-bit address |
| rec_disp_o | output | 16 | Displacement or direct address |
| rec_imm_o | output | 16 | Immediate, sign-extended if 8-bit |
| rec_len_o | output | 3 | Instruction length in bytes |

## Verification
The bench targets the mode 0, r/m 6 direct-address exception. A decoder that treats it as plain [BP] would come up two bytes short and then misparse every later instruction. It checks sign extension with displacement and immediate bytes whose top bit is set, where a zero-extending design would return 00FF instead of FFFF. It sends C7 with a non-zero reg field and unknown opcodes back to back with legal code, which catches a decoder that swallows extra bytes after an illegal opcode or loses its alignment. Randomly stalled record acceptance exposes any record that changes while waiting and any byte taken while a record is pending.

// File: rtl/insn_dec16_pkg.sv
package insn_dec16_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    CLS_MOV_RI  = 3'd0,
    CLS_MOV_MI  = 3'd1,
    CLS_MOV_ACC = 3'd2,
    CLS_MOV_LD  = 3'd3,
    CLS_MOV_ST  = 3'd4,
    CLS_MOV_SEG = 3'd5,
    CLS_ALU_I8  = 3'd6,
    CLS_ADD_ST  = 3'd7
  } insn_cls_e;

  typedef enum logic [2:0] {
    OPK_NONE = 3'd0,
    OPK_REG  = 3'd1,
    OPK_MEM  = 3'd2,
    OPK_IMM  = 3'd3,
    OPK_SEG  = 3'd4
  } opnd_kind_e;

  typedef struct packed {
    insn_cls_e  cls;
    logic       has_modrm;
    logic [1:0] disp_n;
    logic [1:0] imm_n;
    logic       illegal;
  } opc_info_t;
endpackage

// File: rtl/insn_opc_decode.sv
module insn_opc_decode
  import insn_dec16_pkg::*;
(
  input  logic [BYTE_W-1:0] opc_i,
  output opc_info_t         info_o
);
  always_comb begin
    info_o = '{cls: CLS_MOV_RI, has_modrm: 1'b0, disp_n: 2'd0, imm_n: 2'd0, illegal: 1'b1};
    if (opc_i[7:3] == 5'b10111) begin
      info_o.cls = CLS_MOV_RI; info_o.imm_n = 2'd2; info_o.illegal = 1'b0;
    end else begin
      unique case (opc_i)
        8'hC7: begin info_o.cls = CLS_MOV_MI;  info_o.has_modrm = 1'b1; info_o.imm_n = 2'd2; info_o.illegal = 1'b0; end
        8'hA1: begin info_o.cls = CLS_MOV_ACC; info_o.disp_n = 2'd2; info_o.illegal = 1'b0; end
        8'h8B: begin info_o.cls = CLS_MOV_LD;  info_o.has_modrm = 1'b1; info_o.illegal = 1'b0; end
        8'h89: begin info_o.cls = CLS_MOV_ST;  info_o.has_modrm = 1'b1; info_o.illegal = 1'b0; end
        8'h8C: begin info_o.cls = CLS_MOV_SEG; info_o.has_modrm = 1'b1; info_o.illegal = 1'b0; end
        8'h83: begin info_o.cls = CLS_ALU_I8;  info_o.has_modrm = 1'b1; info_o.imm_n = 2'd1; info_o.illegal = 1'b0; end
        8'h01: begin info_o.cls = CLS_ADD_ST;  info_o.has_modrm = 1'b1; info_o.illegal = 1'b0; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/insn_modrm_decode.sv
module insn_modrm_decode
  import insn_dec16_pkg::*;
(
  input  logic [BYTE_W-1:0] modrm_i,
  output logic              is_reg_o,
  output logic              direct_o,
  output logic [1:0]        disp_n_o
);
  logic [1:0] mode;
  logic [2:0] rm;
  assign mode = modrm_i[7:6];
  assign rm   = modrm_i[2:0];

  always_comb begin
    is_reg_o = (mode == 2'd3);
    direct_o = (mode == 2'd0) && (rm == 3'd6);
    unique case (mode)
      2'd0:    disp_n_o = direct_o ? 2'd2 : 2'd0;
      2'd1:    disp_n_o = 2'd1;
      2'd2:    disp_n_o = 2'd2;
      default: disp_n_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/insn_dec16.sv
module insn_dec16
  import insn_dec16_pkg::*;
#(
  parameter int unsigned MAX_LEN = 6,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  output logic              in_ready_o,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic              rec_illegal_o,
  output logic [2:0]        rec_cls_o,
  output logic [2:0]        rec_alu_op_o,
  output logic [2:0]        rec_dst_kind_o,
  output logic [2:0]        rec_dst_num_o,
  output logic [2:0]        rec_src_kind_o,
  output logic [2:0]        rec_src_num_o,
  output logic              rec_direct_o,
  output logic [WORD_W-1:0] rec_disp_o,
  output logic [WORD_W-1:0] rec_imm_o,
  output logic [LEN_W-1:0]  rec_len_o
);
  typedef enum logic [2:0] {S_OPC, S_MODRM, S_DISP, S_IMM, S_EMIT} st_e;

  st_e         st_q;
  insn_cls_e   cls_q;
  logic        hm_q, ill_q, isreg_q, dir_q, idx_q;
  logic [2:0]  opr_q, reg_q, rm_q;
  logic [1:0]  dn_q, in_q;
  logic [WORD_W-1:0] disp_q, imm_q;
  logic [LEN_W-1:0]  len_q;

  opc_info_t   opc_info;
  logic        m_isreg, m_dir;
  logic [1:0]  m_dn;
  logic        fire;
  logic [WORD_W-1:0] sext_byte;

  insn_opc_decode u_opc (.opc_i(in_byte_i), .info_o(opc_info));
  insn_modrm_decode u_modrm (.modrm_i(in_byte_i), .is_reg_o(m_isreg), .direct_o(m_dir), .disp_n_o(m_dn));

  assign in_ready_o = (st_q != S_EMIT);
  assign fire       = in_valid_i && in_ready_o;
  assign sext_byte  = {{(WORD_W-BYTE_W){in_byte_i[7]}}, in_byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_OPC; cls_q <= CLS_MOV_RI; hm_q <= 1'b0; ill_q <= 1'b0;
      isreg_q <= 1'b0; dir_q <= 1'b0; idx_q <= 1'b0;
      opr_q <= '0; reg_q <= '0; rm_q <= '0; dn_q <= '0; in_q <= '0;
      disp_q <= '0; imm_q <= '0; len_q <= '0;
    end else begin
      unique case (st_q)
        S_OPC: if (fire) begin
          opr_q <= in_byte_i[2:0]; cls_q <= opc_info.cls; hm_q <= opc_info.has_modrm;
          ill_q <= opc_info.illegal; dn_q <= opc_info.disp_n; in_q <= opc_info.imm_n;
          len_q <= LEN_W'(1); idx_q <= 1'b0; disp_q <= '0; imm_q <= '0;
          isreg_q <= 1'b0; dir_q <= 1'b0; reg_q <= '0; rm_q <= '0;
          if (opc_info.illegal)          st_q <= S_EMIT;
          else if (opc_info.has_modrm)   st_q <= S_MODRM;
          else if (opc_info.disp_n != 0) st_q <= S_DISP;
          else if (opc_info.imm_n != 0)  st_q <= S_IMM;
          else                           st_q <= S_EMIT;
        end
        S_MODRM: if (fire) begin
          len_q <= len_q + 1'b1;
          reg_q <= in_byte_i[5:3]; rm_q <= in_byte_i[2:0];
          isreg_q <= m_isreg; dir_q <= m_dir;
          // C7 uses reg as an opcode extension: only 0 is defined
          if (cls_q == CLS_MOV_MI && in_byte_i[5:3] != 3'd0) begin
            ill_q <= 1'b1; st_q <= S_EMIT;
          end else begin
            dn_q <= m_dn;
            if (m_dn != 0)      st_q <= S_DISP;
            else if (in_q != 0) st_q <= S_IMM;
            else                st_q <= S_EMIT;
          end
        end
        S_DISP: if (fire) begin
          len_q <= len_q + 1'b1;
          if (!idx_q) disp_q <= sext_byte;
          else        disp_q[WORD_W-1:BYTE_W] <= in_byte_i;
          if ({1'b0, idx_q} + 2'd1 == dn_q) begin
            idx_q <= 1'b0;
            st_q  <= (in_q != 0) ? S_IMM : S_EMIT;
          end else idx_q <= 1'b1;
        end
        S_IMM: if (fire) begin
          len_q <= len_q + 1'b1;
          if (!idx_q) imm_q <= sext_byte;
          else        imm_q[WORD_W-1:BYTE_W] <= in_byte_i;
          if ({1'b0, idx_q} + 2'd1 == in_q) begin
            idx_q <= 1'b0; st_q <= S_EMIT;
          end else idx_q <= 1'b1;
        end
        S_EMIT: if (rec_ready_i) st_q <= S_OPC;
        default: st_q <= S_OPC;
      endcase
    end
  end

  // Operand record
  opnd_kind_e rm_kind, dk, sk;
  logic [2:0] dn, sn, alu;

  always_comb begin
    rm_kind = isreg_q ? OPK_REG : OPK_MEM;
    dk = OPK_NONE; dn = '0; sk = OPK_NONE; sn = '0; alu = '0;
    if (!ill_q) begin
      unique case (cls_q)
        CLS_MOV_RI:  begin dk = OPK_REG; dn = opr_q; sk = OPK_IMM; end
        CLS_MOV_MI:  begin dk = rm_kind; dn = rm_q;  sk = OPK_IMM; end
        CLS_MOV_ACC: begin dk = OPK_REG; dn = 3'd0;  sk = OPK_MEM; sn = 3'd6; end
        CLS_MOV_LD:  begin dk = OPK_REG; dn = reg_q; sk = rm_kind; sn = rm_q; end
        CLS_MOV_ST,
        CLS_ADD_ST:  begin dk = rm_kind; dn = rm_q;  sk = OPK_REG; sn = reg_q; end
        CLS_MOV_SEG: begin dk = rm_kind; dn = rm_q;  sk = OPK_SEG; sn = reg_q; end
        CLS_ALU_I8:  begin dk = rm_kind; dn = rm_q;  sk = OPK_IMM; alu = reg_q; end
        default: ;
      endcase
    end
  end

  assign rec_valid_o    = (st_q == S_EMIT);
  assign rec_illegal_o  = ill_q;
  assign rec_cls_o      = ill_q ? 3'd0 : cls_q;
  assign rec_alu_op_o   = alu;
  assign rec_dst_kind_o = dk;
  assign rec_dst_num_o  = dn;
  assign rec_src_kind_o = sk;
  assign rec_src_num_o  = sn;
  assign rec_direct_o   = !ill_q && ((cls_q == CLS_MOV_ACC) || (hm_q && dir_q));
  assign rec_disp_o     = disp_q;
  assign rec_imm_o      = imm_q;
  assign rec_len_o      = len_q;

  // R10
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_len_o) && $stable(rec_imm_o)
      && $stable(rec_disp_o) && $stable(rec_cls_o) && $stable(rec_dst_num_o));
  // R10
  rec_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_ready_i |=> !rec_valid_o && in_ready_o);
  // R11
  rec_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rec_valid_o) |-> $past(in_valid_i && in_ready_o));
  // R9
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_len_o >= LEN_W'(1)) && (32'(rec_len_o) <= MAX_LEN));
  // R3
  illegal_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_illegal_o |-> rec_len_o <= LEN_W'(2));
  // R2
  short_form_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_illegal_o && rec_cls_o == 3'd0 |-> rec_len_o == LEN_W'(3));
endmodule

// File: tb/tb_insn_dec16.sv
module tb_insn_dec16;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, rec_valid, rec_ready, rec_ill, rec_dir;
  logic [7:0] in_byte;
  logic [2:0] rec_cls, rec_alu, rec_dk, rec_dn, rec_sk, rec_sn, rec_len;
  logic [15:0] rec_disp, rec_imm;

  insn_dec16 dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .in_ready_o(in_ready), .rec_valid_o(rec_valid), .rec_ready_i(rec_ready),
    .rec_illegal_o(rec_ill), .rec_cls_o(rec_cls), .rec_alu_op_o(rec_alu),
    .rec_dst_kind_o(rec_dk), .rec_dst_num_o(rec_dn), .rec_src_kind_o(rec_sk),
    .rec_src_num_o(rec_sn), .rec_direct_o(rec_dir), .rec_disp_o(rec_disp),
    .rec_imm_o(rec_imm), .rec_len_o(rec_len));

  int n_chk = 0, n_bad = 0, cyc = 0;
  string req;
  logic [7:0] pb [8];
  int pn;
  logic e_ill, e_dir;
  logic [2:0] e_cls, e_alu, e_dk, e_dn, e_sk, e_sn;
  logic [15:0] e_disp, e_imm;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic known(input logic [7:0] b);
    return (b[7:3] == 5'b10111) || b == 8'hC7 || b == 8'hA1 || b == 8'h8B ||
           b == 8'h89 || b == 8'h8C || b == 8'h83 || b == 8'h01;
  endfunction

  task automatic push(input logic [7:0] b);
    pb[pn] = b; pn++;
  endtask

  // R4: mode/reg/r/m byte plus its displacement bytes (taken from d)
  task automatic push_modrm(input logic [7:0] m, input logic [15:0] d,
                            output logic [2:0] k, output logic [2:0] num);
    push(m);
    num = m[2:0];
    k = (m[7:6] == 2'd3) ? 3'd1 : 3'd2;
    case (m[7:6])
      2'd0: if (m[2:0] == 3'd6) begin push(d[7:0]); push(d[15:8]); e_disp = d; e_dir = 1'b1; end
      2'd1: begin push(d[7:0]); e_disp = {{8{d[7]}}, d[7:0]}; end
      2'd2: begin push(d[7:0]); push(d[15:8]); e_disp = d; end
      default: ;
    endcase
  endtask

  task automatic push_imm16(input logic [15:0] v);
    push(v[7:0]); push(v[15:8]); e_imm = v;
  endtask

  // r[15:0] feeds displacement bytes, r[31:16] feeds immediate bytes
  task automatic gen(input int sel, input logic [7:0] m, input logic [31:0] r);
    logic [2:0] k, num;
    pn = 0; e_ill = 0; e_dir = 0; e_cls = 0; e_alu = 0;
    e_dk = 0; e_dn = 0; e_sk = 0; e_sn = 0; e_disp = 0; e_imm = 0;
    case (sel)
      0: begin req = "R2"; push(8'hB8 | {5'd0, m[2:0]}); e_cls = 0; e_dk = 1; e_dn = m[2:0]; e_sk = 3; push_imm16(r[31:16]); end
      1: begin
        req = "R3"; push(8'hC7);
        if (m[5:3] != 3'd0) begin push(m); e_ill = 1; end
        else begin push_modrm(m, r[15:0], k, num); e_cls = 1; e_dk = k; e_dn = num; e_sk = 3; push_imm16(r[31:16]); end
      end
      2: begin req = "R5"; push(8'hA1); push(r[7:0]); push(r[15:8]); e_disp = r[15:0]; e_dir = 1; e_cls = 2; e_dk = 1; e_dn = 0; e_sk = 2; e_sn = 6; end
      3: begin req = "R6"; push(8'h8B); push_modrm(m, r[15:0], k, num); e_cls = 3; e_dk = 1; e_dn = m[5:3]; e_sk = k; e_sn = num; end
      4: begin req = "R6"; push(8'h89); push_modrm(m, r[15:0], k, num); e_cls = 4; e_dk = k; e_dn = num; e_sk = 1; e_sn = m[5:3]; end
      5: begin req = "R7"; push(8'h8C); push_modrm(m, r[15:0], k, num); e_cls = 5; e_dk = k; e_dn = num; e_sk = 4; e_sn = m[5:3]; end
      6: begin
        req = "R8"; push(8'h83); push_modrm(m, r[15:0], k, num); e_cls = 6; e_alu = m[5:3];
        e_dk = k; e_dn = num; e_sk = 3; push(r[23:16]); e_imm = {{8{r[23]}}, r[23:16]};
      end
      7: begin req = "R6"; push(8'h01); push_modrm(m, r[15:0], k, num); e_cls = 7; e_dk = k; e_dn = num; e_sk = 1; e_sn = m[5:3]; end
      default: begin req = "R9"; push(m); e_ill = 1; end
    endcase
  endtask

  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_insn(input int stall);
    logic [34:0] snap;
    for (int i = 0; i < pn; i++) begin
      put_byte(pb[i]);
      if (i < pn - 1) chk({req, " R11 no early record"}, 64'(rec_valid), 64'd0);
    end
    chk({req, " R11 record after last byte"}, 64'(rec_valid), 64'd1);
    snap = {rec_len, rec_imm, rec_disp};
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk({req, " R10 held valid"}, 64'(rec_valid), 64'd1);
      chk({req, " R10 no byte while pending"}, 64'(in_ready), 64'd0);
      chk({req, " R10 stable"}, 64'({rec_len, rec_imm, rec_disp}), 64'(snap));
    end
    chk({req, " illegal"}, 64'(rec_ill), 64'(e_ill));
    chk({req, " len"}, 64'(rec_len), 64'(pn));
    chk({req, " class"}, 64'(rec_cls), 64'(e_cls));
    chk({req, " alu"}, 64'(rec_alu), 64'(e_alu));
    chk({req, " dst"}, 64'({rec_dk, rec_dn}), 64'({e_dk, e_dn}));
    chk({req, " src"}, 64'({rec_sk, rec_sn}), 64'({e_sk, e_sn}));
    chk({req, " R4 direct"}, 64'(rec_dir), 64'(e_dir));
    chk({req, " R4 disp"}, 64'(rec_disp), 64'(e_disp));
    chk({req, " imm"}, 64'(rec_imm), 64'(e_imm));
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
    chk({req, " R10 back to fetch"}, 64'({rec_valid, in_ready}), 64'b01);
  endtask

  initial begin
    void'($urandom(32'h5EED_0123));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; rec_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 64'(in_ready), 64'd1);
    chk("R1 reset no record", 64'(rec_valid), 64'd0);

    // directed corner cases
    gen(0, 8'h03, 32'h1234_0000); run_insn(0);            // R2 B8+3
    gen(1, 8'h04, 32'h0000_0000); run_insn(1);            // R3 C7 04 00 00
    gen(1, 8'h2C, 32'h0);         run_insn(0);            // R3 bad reg field
    gen(6, 8'hC1, 32'h00FF_0000); run_insn(0);            // R8 83 C1 FF
    gen(7, 8'h44, 32'h0000_0010); run_insn(2);            // R6 01 44 10
    gen(2, 8'h00, 32'h0000_5678); run_insn(0);            // R5 A1
    gen(8, 8'h90, 32'h0);         run_insn(0);            // R9 unknown
    gen(5, 8'hD8, 32'h0);         run_insn(0);            // R7 8C D8
    gen(3, 8'h16, 32'h0000_1234); run_insn(0);            // R4 direct
    gen(4, 8'h87, 32'h0000_ABCD); run_insn(0);            // R4 mode 2
    gen(3, 8'h4F, 32'h0000_0080); run_insn(0);            // R4 mode 1 sign ext

    for (int it = 0; it < 400; it++) begin
      int sel;
      logic [7:0] m;
      sel = int'($urandom % 9);
      m = 8'($urandom);
      if (sel == 1 && ($urandom % 4) != 0) m[5:3] = 3'd0;
      if (sel == 8) while (known(m)) m = 8'($urandom);
      gen(sel, m, $urandom);
      run_insn(int'($urandom % 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule